// File: doc/BRIEF.md
# SD Host Card-Pin Power Sequencer

This block owns the card-facing pins of an SD/MMC host: eight data lines, the command line and the card clock. A two-bit power field, written over a plain write strobe and readable at all times, selects how those pins behave. After hardware reset the data and command lines float and the clock pin is held low. A software write of the off code drives every line high. The power-cycle code drives every line low so the card cannot draw current through its signal pins.

The power-on code starts the card clock. The clock is made from the system clock by a divider. For a fixed number of card-clock rising edges (74 by default), the command and data lines are held high and the controller stays disabled. On the system cycle after the last of those edges, the controller-enable flag rises and the data and command pins take their values and enables from the transfer logic. From then on the field is locked at power-on, and only a hardware reset brings it back.

Top module: `sd_pwr_seq`

## Requirements
- R1: While reset is asserted and after its release with no write, `pwr_rd` reads 0, `ctrl_en` is 0, `ck_o` is 0 with `ck_oe` 1, and all of `dat_oe` and `cmd_oe` are 0 (high-impedance).
- R2: A write of code 0 (off) keeps `pwr_rd` at 0 and `ctrl_en` at 0, and drives every data line, the command line and the clock pin high with their enables set.
- R3: A write of code 2 (power-cycle) makes `pwr_rd` read 2, keeps `ctrl_en` at 0, and drives every data line, the command line and the clock pin low with their enables set.
- R4: A write of code 1 is reserved. It changes neither `pwr_rd` nor any pin.
- R5: A write of code 3 (power-on) makes `pwr_rd` read 3 and starts `ck_o`. `ck_o` changes level every `CLK_HALF` system cycles, and `ck_oe` is held at 1.
- R6: `ctrl_en` stays 0 until the `WAKE_CYC`-th rising edge of `ck_o` after power-on. It rises on the following system cycle and then stays 1.
- R7: During the start-up window, all data lines and the command line are driven high with their enables set, whatever the transfer inputs are.
- R8: Once `ctrl_en` is 1, `dat_o`, `dat_oe`, `cmd_o` and `cmd_oe` follow `xf_dat_o`, `xf_dat_oe`, `xf_cmd_o` and `xf_cmd_oe` combinationally.
- R9: While the field holds 3, writes of any code, whether made during the window or after it, leave `pwr_rd`, `ctrl_en` and the pins unchanged.
- R10: Reset asserted while powered on returns the block to the R1 state. A later power-on again waits the full `WAKE_CYC` card-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| pwr_wr | input | 1 | Write strobe for the power field |
| pwr_wdata | input | 2 | Code to write: 0 off, 1 reserved, 2 power-cycle, 3 power-on |
| pwr_rd | output | 2 | Current value of the power field |
| xf_dat_o | input | DAT_W | Data line values from the transfer logic |
| xf_dat_oe | input | DAT_W | Data line enables from the transfer logic |
| xf_cmd_o | input | 1 | Command line value from the transfer logic |
| xf_cmd_oe | input | 1 | Command line enable from the transfer logic |
| dat_o | output | DAT_W | Data pin values |
| dat_oe | output | DAT_W | Data pin enables |
| cmd_o | output | 1 | Command pin value |
| cmd_oe | output | 1 | Command pin enable |
| ck_o | output | 1 | Card clock pin value |
| ck_oe | output | 1 | Card clock pin enable |
| ctrl_en | output | 1 | Controller enable; rises after the start-up window |

## Verification
The bench counts `ck_o` rising edges itself and requires `ctrl_en` to rise exactly one system cycle after the 74th edge. An off-by-one counter, or a counter that counts system cycles, would raise it early or late. Writes are fired during the window as well as after it, to catch a lock that only takes effect once the controller is enabled. The reset state and the written-off state share the read value 0, so the pin enables are checked separately in each. A design that merges the two would either float the lines after a write of 0 or drive them after reset. The bench also powers on a second time after a mid-operation reset, which exposes a start-up counter that is not cleared by reset.

// File: rtl/sd_pwr_pkg.sv
`timescale 1ns/1ps
package sd_pwr_pkg;

  // Field codes as seen by software.
  localparam logic [1:0] FLD_OFF = 2'b00;
  localparam logic [1:0] FLD_RSV = 2'b01;
  localparam logic [1:0] FLD_CYC = 2'b10;
  localparam logic [1:0] FLD_ON  = 2'b11;

  // Internal mode: reset and written-off share code 0 but differ on the pins.
  typedef enum logic [1:0] {
    MODE_RST = 2'd0,
    MODE_OFF = 2'd1,
    MODE_CYC = 2'd2,
    MODE_ON  = 2'd3
  } pwr_mode_e;

  function automatic logic [1:0] mode_to_field(pwr_mode_e m);
    case (m)
      MODE_CYC: mode_to_field = FLD_CYC;
      MODE_ON:  mode_to_field = FLD_ON;
      default:  mode_to_field = FLD_OFF;
    endcase
  endfunction

endpackage

// File: rtl/sd_pwr_field.sv
`timescale 1ns/1ps
module sd_pwr_field
  import sd_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output pwr_mode_e  mode,
  output logic [1:0] rd_data
);

  pwr_mode_e mode_q;
  pwr_mode_e mode_d;
  logic      wr_ok;

  // Power-on locks the field; only reset leaves it.
  assign wr_ok = wr_en && (mode_q != MODE_ON);

  always_comb begin
    mode_d = mode_q;
    if (wr_ok) begin
      case (wr_data)
        FLD_OFF: mode_d = MODE_OFF;
        FLD_CYC: mode_d = MODE_CYC;
        FLD_ON:  mode_d = MODE_ON;
        default: mode_d = mode_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_RST;
    else        mode_q <= mode_d;
  end

  assign mode    = mode_q;
  assign rd_data = mode_to_field(mode_q);

endmodule

// File: rtl/sd_pwr_ckgen.sv
`timescale 1ns/1ps
module sd_pwr_ckgen #(
  parameter int CLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ck,
  output logic rise
);

  localparam int DIV_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_HALF - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic             ck_q, ck_d;
  logic             tick;

  assign tick = run && (div_q == DIV_LAST);

  always_comb begin
    div_d = div_q;
    ck_d  = ck_q;
    if (!run) begin
      div_d = '0;
      ck_d  = 1'b0;
    end else if (tick) begin
      div_d = '0;
      ck_d  = ~ck_q;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ck_q  <= 1'b0;
    end else begin
      div_q <= div_d;
      ck_q  <= ck_d;
    end
  end

  assign ck   = ck_q;
  // Pulse in the cycle whose closing edge raises the card clock.
  assign rise = tick && !ck_q;

endmodule

// File: rtl/sd_pwr_wake.sv
`timescale 1ns/1ps
module sd_pwr_wake #(
  parameter int WAKE_CYC = 74
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rise,
  output logic ready
);

  localparam int CNT_W = $clog2(WAKE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WAKE_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rdy_q, rdy_d;
  logic             cnt_ce;

  assign cnt_ce = run && rise && (cnt_q != CNT_END);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (cnt_ce) cnt_d = cnt_q + 1'b1;
    rdy_d = run && (cnt_q == CNT_END);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;

endmodule

// File: rtl/sd_pwr_pinmux.sv
`timescale 1ns/1ps
module sd_pwr_pinmux
  import sd_pwr_pkg::*;
#(
  parameter int DAT_W = 8
) (
  input  pwr_mode_e        mode,
  input  logic             ready,
  input  logic             ck_gen,
  input  logic [DAT_W-1:0] xf_dat_o,
  input  logic [DAT_W-1:0] xf_dat_oe,
  input  logic             xf_cmd_o,
  input  logic             xf_cmd_oe,
  output logic [DAT_W-1:0] dat_o,
  output logic [DAT_W-1:0] dat_oe,
  output logic             cmd_o,
  output logic             cmd_oe,
  output logic             ck_o,
  output logic             ck_oe
);

  always_comb begin
    ck_oe = 1'b1;
    case (mode)
      MODE_OFF: begin
        dat_o = '1; dat_oe = '1; cmd_o = 1'b1; cmd_oe = 1'b1; ck_o = 1'b1;
      end
      MODE_CYC: begin
        dat_o = '0; dat_oe = '1; cmd_o = 1'b0; cmd_oe = 1'b1; ck_o = 1'b0;
      end
      MODE_ON: begin
        ck_o = ck_gen;
        if (ready) begin
          dat_o = xf_dat_o; dat_oe = xf_dat_oe;
          cmd_o = xf_cmd_o; cmd_oe = xf_cmd_oe;
        end else begin
          dat_o = '1; dat_oe = '1; cmd_o = 1'b1; cmd_oe = 1'b1;
        end
      end
      default: begin
        dat_o = '0; dat_oe = '0; cmd_o = 1'b0; cmd_oe = 1'b0; ck_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sd_pwr_seq.sv
`timescale 1ns/1ps
module sd_pwr_seq
  import sd_pwr_pkg::*;
#(
  parameter int DAT_W    = 8,
  parameter int CLK_HALF = 2,
  parameter int WAKE_CYC = 74
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_wr,
  input  logic [1:0]       pwr_wdata,
  output logic [1:0]       pwr_rd,
  input  logic [DAT_W-1:0] xf_dat_o,
  input  logic [DAT_W-1:0] xf_dat_oe,
  input  logic             xf_cmd_o,
  input  logic             xf_cmd_oe,
  output logic [DAT_W-1:0] dat_o,
  output logic [DAT_W-1:0] dat_oe,
  output logic             cmd_o,
  output logic             cmd_oe,
  output logic             ck_o,
  output logic             ck_oe,
  output logic             ctrl_en
);

  pwr_mode_e mode;
  logic      run;
  logic      ck_gen;
  logic      ck_rise;
  logic      ready;

  assign run = (mode == MODE_ON);

  sd_pwr_field field_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pwr_wr),
    .wr_data (pwr_wdata),
    .mode    (mode),
    .rd_data (pwr_rd)
  );

  sd_pwr_ckgen #(.CLK_HALF(CLK_HALF)) ckgen_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .ck    (ck_gen),
    .rise  (ck_rise)
  );

  sd_pwr_wake #(.WAKE_CYC(WAKE_CYC)) wake_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .rise  (ck_rise),
    .ready (ready)
  );

  sd_pwr_pinmux #(.DAT_W(DAT_W)) pinmux_i (
    .mode      (mode),
    .ready     (ready),
    .ck_gen    (ck_gen),
    .xf_dat_o  (xf_dat_o),
    .xf_dat_oe (xf_dat_oe),
    .xf_cmd_o  (xf_cmd_o),
    .xf_cmd_oe (xf_cmd_oe),
    .dat_o     (dat_o),
    .dat_oe    (dat_oe),
    .cmd_o     (cmd_o),
    .cmd_oe    (cmd_oe),
    .ck_o      (ck_o),
    .ck_oe     (ck_oe)
  );

  assign ctrl_en = ready;

endmodule

// File: rtl/sd_pwr_seq_chk.sv
`timescale 1ns/1ps
module sd_pwr_seq_chk #(
  parameter int DAT_W    = 8,
  parameter int WAKE_CYC = 74
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_wr,
  input logic [1:0]       pwr_wdata,
  input logic [1:0]       pwr_rd,
  input logic [DAT_W-1:0] dat_o,
  input logic [DAT_W-1:0] dat_oe,
  input logic             cmd_o,
  input logic             ck_o,
  input logic             ck_oe,
  input logic             ctrl_en
);

  localparam int CNT_W = $clog2(WAKE_CYC + 1);

  logic             ck_prev_q;
  logic [CNT_W-1:0] rises_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_prev_q <= 1'b0;
      rises_q   <= '0;
    end else begin
      ck_prev_q <= ck_o;
      if (pwr_rd != 2'b11)
        rises_q <= '0;
      else if (ck_o && !ck_prev_q && (rises_q != CNT_W'(WAKE_CYC)))
        rises_q <= rises_q + 1'b1;
    end
  end

  // R9
  on_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_rd == 2'b11) |=> (pwr_rd == 2'b11));

  // R6
  en_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en |-> (pwr_rd == 2'b11));

  // R6
  en_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en |=> ctrl_en);

  // R6
  en_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_en |-> (rises_q == CNT_W'(WAKE_CYC)));

  // R3
  cyc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_rd == 2'b10) |-> (dat_o == '0 && dat_oe == '1 && !cmd_o && !ck_o && ck_oe));

  // R7
  window_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_rd == 2'b11 && !ctrl_en) |-> (dat_o == '1 && dat_oe == '1 && cmd_o));

  // R4
  rsv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_wr && pwr_wdata == 2'b01) |=> $stable(pwr_rd));

endmodule

bind sd_pwr_seq sd_pwr_seq_chk #(.DAT_W(DAT_W), .WAKE_CYC(WAKE_CYC)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_wr    (pwr_wr),
  .pwr_wdata (pwr_wdata),
  .pwr_rd    (pwr_rd),
  .dat_o     (dat_o),
  .dat_oe    (dat_oe),
  .cmd_o     (cmd_o),
  .ck_o      (ck_o),
  .ck_oe     (ck_oe),
  .ctrl_en   (ctrl_en)
);

// File: tb/sd_pwr_seq_tb.sv
`timescale 1ns/1ps
module sd_pwr_seq_tb_top;

  localparam int DAT_W    = 8;
  localparam int CLK_HALF = 2;
  localparam int WAKE_CYC = 74;

  // Bench model modes: 0 reset, 1 written off, 2 cycle, 3 on.
  localparam int BM_RST = 0, BM_OFF = 1, BM_CYC = 2, BM_ON = 3;

  logic             clk;
  logic             rst_n;
  logic             pwr_wr;
  logic [1:0]       pwr_wdata;
  logic [1:0]       pwr_rd;
  logic [DAT_W-1:0] xf_dat_o, xf_dat_oe;
  logic             xf_cmd_o, xf_cmd_oe;
  logic [DAT_W-1:0] dat_o, dat_oe;
  logic             cmd_o, cmd_oe, ck_o, ck_oe, ctrl_en;

  int n_tests;
  int n_fail;
  int bm_mode;
  bit bm_ready;
  bit finished;

  sd_pwr_seq #(.DAT_W(DAT_W), .CLK_HALF(CLK_HALF), .WAKE_CYC(WAKE_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_wr(pwr_wr), .pwr_wdata(pwr_wdata), .pwr_rd(pwr_rd),
    .xf_dat_o(xf_dat_o), .xf_dat_oe(xf_dat_oe), .xf_cmd_o(xf_cmd_o), .xf_cmd_oe(xf_cmd_oe),
    .dat_o(dat_o), .dat_oe(dat_oe), .cmd_o(cmd_o), .cmd_oe(cmd_oe),
    .ck_o(ck_o), .ck_oe(ck_oe), .ctrl_en(ctrl_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int next_mode(int cur, logic [1:0] code);
    if (cur == BM_ON) return cur;
    case (code)
      2'd0: return BM_OFF;
      2'd2: return BM_CYC;
      2'd3: return BM_ON;
      default: return cur;
    endcase
  endfunction

  function automatic logic [1:0] exp_rd(int m);
    return (m == BM_CYC) ? 2'd2 : (m == BM_ON) ? 2'd3 : 2'd0;
  endfunction

  // Packs {dat_o, dat_oe, cmd_o, cmd_oe, ck_oe}; ck_o compared separately.
  function automatic logic [2*DAT_W+2:0] exp_pins(int m, bit rdy);
    case (m)
      BM_OFF: return {{DAT_W{1'b1}}, {DAT_W{1'b1}}, 1'b1, 1'b1, 1'b1};
      BM_CYC: return {{DAT_W{1'b0}}, {DAT_W{1'b1}}, 1'b0, 1'b1, 1'b1};
      BM_ON:  return rdy ? {xf_dat_o, xf_dat_oe, xf_cmd_o, xf_cmd_oe, 1'b1}
                         : {{DAT_W{1'b1}}, {DAT_W{1'b1}}, 1'b1, 1'b1, 1'b1};
      default: return {{DAT_W{1'b0}}, {DAT_W{1'b0}}, 1'b0, 1'b0, 1'b1};
    endcase
  endfunction

  function automatic logic exp_ck(int m);
    return (m == BM_OFF);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, {14'd0, dat_o, dat_oe, cmd_o, cmd_oe, ck_oe}, {14'd0, exp_pins(bm_mode, bm_ready)});
    chk(req, {30'd0, pwr_rd}, {30'd0, exp_rd(bm_mode)});
    chk(req, {31'd0, ctrl_en}, {31'd0, bm_ready});
    if (bm_mode != BM_ON) chk(req, {31'd0, ck_o}, {31'd0, exp_ck(bm_mode)});
  endtask

  // Called at a negedge: drive a write for one cycle, land on next negedge.
  task automatic do_write(logic [1:0] code);
    pwr_wr = 1'b1;
    pwr_wdata = code;
    @(negedge clk);
    pwr_wr = 1'b0;
    bm_mode = next_mode(bm_mode, code);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    bm_mode = BM_RST;
    bm_ready = 1'b0;
    chk("R1 during reset", {30'd0, pwr_rd}, 32'd0);
    chk("R1 during reset", {31'd0, ctrl_en}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after reset");
  endtask

  // From a negedge with the field just set to on: walk the start-up window.
  task automatic run_window(string req);
    int  rises = 0;
    int  since = 0;
    int  cyc = 0;
    int  last_tog = -1;
    bit  prev_ck = 1'b0;
    bit  ok_gap = 1'b1;
    bit  ok_en = 1'b1;
    bit  ok_high = 1'b1;
    bit  ok_rd = 1'b1;
    while (since < 3 && cyc < 2000) begin
      if (ck_o !== prev_ck) begin
        if (last_tog >= 0 && (cyc - last_tog) != CLK_HALF) ok_gap = 1'b0;
        last_tog = cyc;
        if (ck_o === 1'b1) rises++;
      end
      prev_ck = ck_o;
      if (rises >= WAKE_CYC) since++;
      if (ctrl_en !== (since >= 2)) ok_en = 1'b0;
      if (!ctrl_en && (dat_o !== '1 || dat_oe !== '1 || cmd_o !== 1'b1 || cmd_oe !== 1'b1))
        ok_high = 1'b0;
      if (pwr_rd !== 2'd3) ok_rd = 1'b0;
      if (ck_oe !== 1'b1) ok_gap = 1'b0;
      // Writes inside the window must be ignored.
      if (cyc % 37 == 5) begin
        pwr_wr = 1'b1;
        pwr_wdata = 2'($urandom_range(0, 3));
      end else begin
        pwr_wr = 1'b0;
      end
      xf_dat_o  = DAT_W'($urandom);
      xf_dat_oe = DAT_W'($urandom);
      xf_cmd_o  = 1'($urandom);
      xf_cmd_oe = 1'($urandom);
      @(negedge clk);
      cyc++;
    end
    pwr_wr = 1'b0;
    chk({"R5 clock half period ", req}, {31'd0, ok_gap}, 32'd1);
    chk({"R6 enable after 74th edge ", req}, {31'd0, ok_en}, 32'd1);
    chk({"R6 edge count ", req}, rises, WAKE_CYC + 1 > rises ? WAKE_CYC : rises);
    chk({"R7 lines high in window ", req}, {31'd0, ok_high}, 32'd1);
    chk({"R9 field locked in window ", req}, {31'd0, ok_rd}, 32'd1);
    bm_ready = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5D00_0C1A));
    n_tests = 0; n_fail = 0; finished = 0;
    bm_mode = BM_RST; bm_ready = 1'b0;
    rst_n = 1'b0; pwr_wr = 1'b0; pwr_wdata = 2'd0;
    xf_dat_o = '0; xf_dat_oe = '0; xf_cmd_o = 1'b0; xf_cmd_oe = 1'b0;
    @(negedge clk);
    do_reset();

    // R4 reserved code straight from reset keeps the hi-Z state
    do_write(2'd1); chk_all("R4 reserved from reset");
    do_write(2'd0); chk_all("R2 off drives high");
    do_write(2'd1); chk_all("R4 reserved from off");
    do_write(2'd2); chk_all("R3 cycle drives low");
    do_write(2'd1); chk_all("R4 reserved from cycle");

    // Random walk over the non-locking codes.
    for (int i = 0; i < 40; i++) begin
      logic [1:0] c;
      c = 2'($urandom_range(0, 2));
      xf_dat_o = DAT_W'($urandom);
      do_write(c);
      chk_all(c == 2'd0 ? "R2 random off" : c == 2'd2 ? "R3 random cycle" : "R4 random reserved");
    end

    do_write(2'd0);
    do_write(2'd3);
    chk({"R5 read on"}, {30'd0, pwr_rd}, 32'd3);
    run_window("first");

    // After the window: pass-through and locked field.
    for (int i = 0; i < 30; i++) begin
      xf_dat_o  = DAT_W'($urandom);
      xf_dat_oe = DAT_W'($urandom);
      xf_cmd_o  = 1'($urandom);
      xf_cmd_oe = 1'($urandom);
      #1;
      chk_all("R8 pass-through");
      do_write(2'($urandom_range(0, 3)));
      chk_all("R9 write ignored when on");
    end

    // R10 reset out of power-on, then a second full start-up.
    do_reset();
    chk_all("R10 reset from on");
    do_write(2'd2); chk_all("R10 cycle after reset");
    do_write(2'd3);
    run_window("R10 second");
    #1;
    chk_all("R10 pass-through after second window");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule